// File: doc/BRIEF.md
# Multidrop address frame filter

This block sits between a serial receiver and its receive buffer on a shared multidrop bus. For each received frame it works out the frame-type bit. In 9-bit character mode that bit is the top data bit. In the shorter character modes it is the first stop bit. A type bit of one marks an address frame and a type bit of zero marks a data frame.

While the filter is enabled, only address frames reach the buffer. Data frames are dropped with no strobe and no error indication. A node that finds itself addressed clears the enable, so the data frames that follow pass through. The host can clear it with a write, or an optional auto-match can clear it when an address frame equals the programmed node address. A node that is not addressed keeps the filter on until the next address frame. The transmit path is not touched.

Accepted frames come out one clock after the input strobe, with the word, an address-frame flag and the frame error flag.

Top module: `mdrop_filter`

## Requirements
- R1: With `rx_nine_i`=1, the frame type is `rx_word_i[8]`, and `rx_stop1_i` is ignored.
- R2: With `rx_nine_i`=0, the frame type is `rx_stop1_i`, and `rx_word_i[8]` is ignored.
- R3: A frame-type bit of 1 is an address frame and gives `out_addr_o`=1. A frame-type bit of 0 is a data frame and gives `out_addr_o`=0.
- R4: While `filt_en_o`=1, a data frame produces no `out_valid_o` pulse.
- R5: An address frame is passed whatever the value of `filt_en_o`.
- R6: While `filt_en_o`=0, every frame is passed.
- R7: A pulse on `en_wr_i` loads `en_wdata_i` into `filt_en_o` on the next clock edge. A frame whose strobe arrives in the same cycle as the write is filtered with the old value.
- R8: With `auto_en_i`=1 and `filt_en_o`=1, an address frame with `rx_word_i[7:0]` equal to `node_addr_i` is passed and clears `filt_en_o`. An address frame that does not match is passed and leaves `filt_en_o` at 1.
- R9: With `auto_en_i`=0, a matching address frame leaves `filt_en_o` unchanged.
- R10: `out_ferr_o` follows `rx_ferr_i` for passed frames and stays 0 for dropped frames.
- R11: A passed frame appears on `out_valid_o` exactly one clock after `rx_valid_i`, with `out_word_o` equal to `rx_word_i`.
- R12: After reset, `filt_en_o`=0 and `out_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received frame strobe |
| rx_word_i | input | DATA_W (9) | Received character |
| rx_stop1_i | input | 1 | First stop bit of the frame |
| rx_nine_i | input | 1 | 1 = 9-bit character mode |
| rx_ferr_i | input | 1 | Frame error of the received frame |
| en_wr_i | input | 1 | Write strobe for the filter enable |
| en_wdata_i | input | 1 | Value written to the filter enable |
| auto_en_i | input | 1 | Enables clearing on a node address match |
| node_addr_i | input | ADDR_W (8) | Node address for the auto-match |
| out_valid_o | output | 1 | Accepted frame strobe |
| out_word_o | output | DATA_W (9) | Accepted character |
| out_addr_o | output | 1 | Accepted frame is an address frame |
| out_ferr_o | output | 1 | Frame error of the accepted frame |
| filt_en_o | output | 1 | Current filter enable |

## Verification
Some frames are sent with the top data bit and the stop bit set to opposite values. This shows in each character mode which bit the type decode actually uses. Data frames and address frames are sent with the filter on and with it off, some carrying a frame error, which separates dropping from passing and shows that the error flag is suppressed. Auto-match is driven with a mismatching address, a matching address, and a matching address with auto-match off, so clearing happens only on a true match. Enable writes are placed in the same cycle as a frame strobe to show that the frame sees the old setting and the next frame sees the new one.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  typedef enum logic {
    FT_DATA = 1'b0,
    FT_ADDR = 1'b1
  } ftype_e;
endpackage

// File: rtl/mdrop_type_sel.sv
module mdrop_type_sel
  import mdrop_pkg::*;
(
  input  logic   word_msb_i,
  input  logic   stop1_i,
  input  logic   nine_i,
  output ftype_e ftype_o
);
  always_comb begin
    if (nine_i) ftype_o = word_msb_i ? FT_ADDR : FT_DATA;
    else        ftype_o = stop1_i    ? FT_ADDR : FT_DATA;
  end
endmodule

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] word_i,
  input  logic [ADDR_W-1:0] node_i,
  output logic              match_o
);
  logic [ADDR_W-1:0] bit_eq;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    assign bit_eq[b] = ~(word_i[b] ^ node_i[b]);
  end

  assign match_o = &bit_eq;
endmodule

// File: rtl/mdrop_en_ctrl.sv
module mdrop_en_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_wr_i,
  input  logic sw_data_i,
  input  logic auto_clr_i,
  output logic en_o
);
  logic en_q;

  // software write wins over an auto clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         en_q <= 1'b0;
    else if (sw_wr_i)    en_q <= sw_data_i;
    else if (auto_clr_i) en_q <= 1'b0;
  end

  assign en_o = en_q;

  a_r7_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr_i |=> (en_o == $past(sw_data_i)));

  a_r8_auto_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_clr_i && !sw_wr_i) |=> !en_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_wr_i && !auto_clr_i) |=> $stable(en_o));
endmodule

// File: rtl/mdrop_filter.sv
module mdrop_filter
  import mdrop_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_stop1_i,
  input  logic              rx_nine_i,
  input  logic              rx_ferr_i,
  input  logic              en_wr_i,
  input  logic              en_wdata_i,
  input  logic              auto_en_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_word_o,
  output logic              out_addr_o,
  output logic              out_ferr_o,
  output logic              filt_en_o
);
  localparam int MsbIdx = DATA_W - 1;

  ftype_e ftype;
  logic   is_addr;
  logic   match;
  logic   accept;
  logic   auto_clr;
  logic   en;

  mdrop_type_sel i_type_sel (
    .word_msb_i (rx_word_i[MsbIdx]),
    .stop1_i    (rx_stop1_i),
    .nine_i     (rx_nine_i),
    .ftype_o    (ftype)
  );

  mdrop_addr_match #(.ADDR_W(ADDR_W)) i_match (
    .word_i  (rx_word_i[ADDR_W-1:0]),
    .node_i  (node_addr_i),
    .match_o (match)
  );

  assign is_addr  = (ftype == FT_ADDR);
  assign accept   = rx_valid_i && (!en || is_addr);
  assign auto_clr = rx_valid_i && is_addr && en && auto_en_i && match;

  mdrop_en_ctrl i_en_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_wr_i    (en_wr_i),
    .sw_data_i  (en_wdata_i),
    .auto_clr_i (auto_clr),
    .en_o       (en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
      out_addr_o  <= 1'b0;
      out_ferr_o  <= 1'b0;
    end else begin
      out_valid_o <= accept;
      out_ferr_o  <= accept && rx_ferr_i;
      if (accept) begin
        out_word_o <= rx_word_i;
        out_addr_o <= is_addr;
      end
    end
  end

  assign filt_en_o = en;

  a_r4_drop_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && filt_en_o && !is_addr) |=> !out_valid_o);

  a_r5_pass_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && is_addr) |=> (out_valid_o && out_addr_o));

  a_r6_pass_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !filt_en_o) |=> out_valid_o);

  a_r10_ferr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ferr_o |-> out_valid_o);

  a_r11_word_passed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (out_word_o == $past(rx_word_i)));
endmodule

// File: tb/test_mdrop_filter.sv
`timescale 1ns/1ps
module test_mdrop_filter;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic [DATA_W-1:0] rx_word = '0;
  logic              rx_stop1 = 1'b0;
  logic              rx_nine = 1'b0;
  logic              rx_ferr = 1'b0;
  logic              en_wr = 1'b0;
  logic              en_wdata = 1'b0;
  logic              auto_en = 1'b0;
  logic [ADDR_W-1:0] node_addr = '0;
  logic              out_valid;
  logic [DATA_W-1:0] out_word;
  logic              out_addr;
  logic              out_ferr;
  logic              filt_en;

  int errors = 0;
  int checks = 0;
  bit en_m = 1'b0;
  bit done = 1'b0;
  logic [DATA_W+1:0] exp_q[$];
  string             tag_q[$];

  always #2 clk = ~clk;

  mdrop_filter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mdrop_filter (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_word_i(rx_word),
    .rx_stop1_i(rx_stop1), .rx_nine_i(rx_nine), .rx_ferr_i(rx_ferr),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .auto_en_i(auto_en),
    .node_addr_i(node_addr), .out_valid_o(out_valid), .out_word_o(out_word),
    .out_addr_o(out_addr), .out_ferr_o(out_ferr), .filt_en_o(filt_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one frame; optional enable write in the same cycle
  task automatic send(input logic [DATA_W-1:0] w, input logic s1, input logic nine,
                      input logic fe, input string tag,
                      input bit wr = 1'b0, input bit wd = 1'b0);
    bit addr;
    bit acc;
    @(negedge clk);
    rx_valid = 1'b1; rx_word = w; rx_stop1 = s1; rx_nine = nine; rx_ferr = fe;
    en_wr = wr; en_wdata = wd;
    addr = nine ? w[8] : s1;
    acc  = !en_m || addr;
    if (acc) begin
      exp_q.push_back({addr, fe, w});
      tag_q.push_back(tag);
    end
    if (wr) en_m = wd;
    else if (auto_en && addr && en_m && (w[7:0] == node_addr)) en_m = 1'b0;
    @(negedge clk);
    rx_valid = 1'b0; en_wr = 1'b0;
    if (!acc) begin
      check(out_valid == 1'b0, {tag, " drop valid"}, out_valid, 0);
      check(out_ferr == 1'b0, {tag, " drop ferr"}, out_ferr, 0);
    end
  endtask

  task automatic sw_write(input bit v);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0;
    en_m = v;
  endtask

  task automatic check_en(input string tag);
    check(filt_en == en_m, tag, filt_en, en_m);
  endtask

  // monitor: compares every accepted frame with the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 unexpected frame: actual=%0h expected=none", out_word);
      end else begin
        logic [DATA_W+1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({out_addr, out_ferr, out_word} == e, t,
              {out_addr, out_ferr, out_word}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(filt_en == 1'b0, "R12 enable after reset", filt_en, 0);
    check(out_valid == 1'b0, "R12 valid after reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // filter off: type selection
    send(9'h055, 1'b1, 1'b1, 1'b0, "R1 nine-bit data, stop ignored");
    send(9'h1AA, 1'b0, 1'b1, 1'b0, "R1 nine-bit address");
    send(9'h0F0, 1'b1, 1'b0, 1'b0, "R2 short address via stop");
    send(9'h10F, 1'b0, 1'b0, 1'b1, "R2 short data, bit8 ignored");
    send(9'h033, 1'b0, 1'b1, 1'b1, "R6 pass when off with ferr");

    // filter on
    sw_write(1'b1);
    check_en("R7 write sets enable");
    send(9'h012, 1'b0, 1'b1, 1'b1, "R4 data dropped R10");
    send(9'h134, 1'b0, 1'b0, 1'b1, "R4 short data dropped");
    send(9'h1C3, 1'b0, 1'b1, 1'b1, "R5 address passes R10 ferr");
    send(9'h0E1, 1'b1, 1'b0, 1'b0, "R5 R3 short address passes");
    check_en("R5 enable kept");

    // auto-match
    auto_en = 1'b1; node_addr = 8'h3C;
    send(9'h1A5, 1'b0, 1'b1, 1'b0, "R8 mismatch address passes");
    check_en("R8 mismatch keeps enable");
    send(9'h03C, 1'b0, 1'b1, 1'b0, "R8 data with node value dropped");
    check_en("R8 data does not clear");
    send(9'h13C, 1'b0, 1'b1, 1'b0, "R8 match address passes");
    check_en("R8 match clears enable");
    send(9'h077, 1'b0, 1'b1, 1'b0, "R8 data after select passes");

    // auto off
    sw_write(1'b1);
    auto_en = 1'b0;
    send(9'h13C, 1'b0, 1'b1, 1'b0, "R9 match without auto passes");
    check_en("R9 enable unchanged");

    // same-cycle writes
    send(9'h011, 1'b0, 1'b1, 1'b0, "R7 old enable drops", 1'b1, 1'b0);
    check_en("R7 write 0 taken");
    send(9'h022, 1'b0, 1'b1, 1'b0, "R7 next frame passes");
    send(9'h044, 1'b0, 1'b1, 1'b0, "R7 old disable passes", 1'b1, 1'b1);
    check_en("R7 write 1 taken");
    send(9'h088, 1'b0, 1'b1, 1'b0, "R7 next frame dropped");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all expected frames seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule